// File: doc/BRIEF.md
# Video window and subsampling selector

This block sits in a camera pixel path and turns a full 640x480 raster into a smaller picture. It watches a frame valid flag and a line valid flag that come with each pixel. It counts column and row positions from 1. It keeps or drops each pixel according to the picture size chosen for the current frame. The kept pixels leave one clock later with new valid flags. Dropped pixels keep their cycle, but line valid is low on it, so the output stream may be sparse.

Five sizes are supported. Full size passes every pixel. Half size keeps every second pixel in both directions. Quarter size keeps every fourth. A centred zoom window covers half of each dimension and can be output either whole or decimated by two. The size code is taken once, in the cycle where frame valid rises, so a frame never mixes two sizes. Markers flag the first kept pixel of each frame and of each kept line. All dimensions are parameters; the zoom window and the decimation grid are derived from them.

Top module: `vsub_select`

## Requirements
- R1: While rst_ni is low, and after its release until input arrives, frame_valid_o, line_valid_o, frame_start_o and line_start_o are 0.
- R2: Size code 0 (full) keeps every pixel, columns 1..IMG_W and rows 1..IMG_H. Codes 5, 6 and 7 behave as code 0.
- R3: Size code 1 (half) keeps pixels whose column and row are both odd, giving IMG_W/2 x IMG_H/2.
- R4: Size code 2 (half, zoom) keeps every pixel with column in IMG_W/4+1..3*IMG_W/4 and row in IMG_H/4+1..3*IMG_H/4.
- R5: Size code 3 (quarter) keeps pixels with (column-1) mod 4 = 0 and (row-1) mod 4 = 0, giving IMG_W/4 x IMG_H/4.
- R6: Size code 4 (quarter, zoom) keeps pixels inside the R4 window whose offset from the window origin is even in both directions. The origin is kept, and the output is IMG_W/4 x IMG_H/4.
- R7: size_i is sampled only in the cycle where frame_valid_i rises. A change of size_i during a frame has no effect until the next frame.
- R8: The block has exactly one cycle of latency. frame_valid_o equals frame_valid_i of the previous cycle, and on every cycle with line_valid_o high, pix_o equals the pixel input of the previous cycle.
- R9: line_valid_o is high only for kept pixels, and never while frame_valid_o is low.
- R10: frame_start_o pulses together with the first kept pixel of a frame. line_start_o pulses together with the first kept pixel of each line that has kept pixels.
- R11: Columns count from 1 at the first line valid cycle of a line. Rows count from 1 at the first line of a frame and advance when line_valid_i falls. Lines are separated by at least one cycle with line_valid_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| size_i | input | 3 | Picture size code, sampled at frame start |
| frame_valid_i | input | 1 | Input frame valid |
| line_valid_i | input | 1 | Input line valid (pixel valid) |
| pix_i | input | DATA_W | Input pixel |
| frame_valid_o | output | 1 | Output frame valid, input delayed one cycle |
| line_valid_o | output | 1 | Output pixel valid, high on kept pixels only |
| pix_o | output | DATA_W | Output pixel |
| frame_start_o | output | 1 | First kept pixel of the frame |
| line_start_o | output | 1 | First kept pixel of the line |

## Verification
A wrong column or row count moves the keep pattern, so line_valid_o shows up in the wrong cycle. For column errors this happens within the same line; for row errors it happens on the next line, and the markers shift with it. A size latch that follows size_i mid-frame changes the kept pattern in the first line after the change. A missing or extra pipeline stage shifts every output by one cycle at once. The bench sweeps every cycle of whole frames in all size codes on a small raster and compares each output cycle with an arithmetic model.

// File: rtl/vsub_pkg.sv
package vsub_pkg;

  typedef enum logic [2:0] {
    SZ_FULL         = 3'd0,
    SZ_HALF         = 3'd1,
    SZ_HALF_ZOOM    = 3'd2,
    SZ_QUARTER      = 3'd3,
    SZ_QUARTER_ZOOM = 3'd4
  } size_e;

  typedef struct packed {
    logic       zoom;
    logic [1:0] dec_log2;
  } geom_t;

  function automatic geom_t size_decode(input logic [2:0] code);
    geom_t g;
    unique case (code)
      SZ_HALF:         g = '{zoom: 1'b0, dec_log2: 2'd1};
      SZ_HALF_ZOOM:    g = '{zoom: 1'b1, dec_log2: 2'd0};
      SZ_QUARTER:      g = '{zoom: 1'b0, dec_log2: 2'd2};
      SZ_QUARTER_ZOOM: g = '{zoom: 1'b1, dec_log2: 2'd1};
      default:         g = '{zoom: 1'b0, dec_log2: 2'd0};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/vsub_raster.sv
module vsub_raster #(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  localparam int CW = $clog2(IMG_W + 1),
  localparam int RW = $clog2(IMG_H + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_valid_i,
  input  logic          line_valid_i,
  output logic [CW-1:0] col_o,
  output logic [RW-1:0] row_o
);

  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic          lv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
      lv_q  <= 1'b0;
    end else begin
      lv_q  <= line_valid_i;
      col_q <= line_valid_i ? col_q + 1'b1 : '0;
      if (!frame_valid_i)              row_q <= '0;
      else if (lv_q && !line_valid_i)  row_q <= row_q + 1'b1;
    end
  end

  // 1-based position of the pixel presented this cycle
  assign col_o = col_q + 1'b1;
  assign row_o = row_q + 1'b1;

  assert_col_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_i |-> (col_q < CW'(IMG_W)));

endmodule

// File: rtl/vsub_axis_gate.sv
module vsub_axis_gate #(
  parameter int LEN = 640,
  localparam int PW = $clog2(LEN + 1),
  localparam int WIN_LO = LEN / 4 + 1,
  localparam int WIN_HI = (3 * LEN) / 4
) (
  input  logic [PW-1:0] pos_i,
  input  logic          zoom_i,
  input  logic [1:0]    dec_log2_i,
  output logic          keep_o
);

  logic [PW-1:0] lo, hi, off, mask;

  always_comb begin
    lo   = zoom_i ? PW'(WIN_LO) : PW'(1);
    hi   = zoom_i ? PW'(WIN_HI) : PW'(LEN);
    off  = pos_i - lo;
    unique case (dec_log2_i)
      2'd0:    mask = PW'(0);
      2'd1:    mask = PW'(1);
      default: mask = PW'(3);
    endcase
    keep_o = (pos_i >= lo) && (pos_i <= hi) && ((off & mask) == '0);
  end

endmodule

// File: rtl/vsub_select.sv
module vsub_select
  import vsub_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMG_W  = 640,
  parameter int IMG_H  = 480,
  localparam int CW = $clog2(IMG_W + 1),
  localparam int RW = $clog2(IMG_H + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        size_i,
  input  logic              frame_valid_i,
  input  logic              line_valid_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic              frame_valid_o,
  output logic              line_valid_o,
  output logic [DATA_W-1:0] pix_o,
  output logic              frame_start_o,
  output logic              line_start_o
);

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [2:0]    mode_q, mode_eff;
  logic          frame_rise, keep_x, keep_y, keep;
  logic          line_seen_q, frame_seen_q;
  geom_t         geom;

  vsub_raster #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_raster (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_valid_i (frame_valid_i),
    .line_valid_i  (line_valid_i),
    .col_o         (col),
    .row_o         (row)
  );

  // frame_valid_o doubles as the previous-cycle frame flag
  assign frame_rise = frame_valid_i && !frame_valid_o;
  assign mode_eff   = frame_rise ? size_i : mode_q;
  assign geom       = size_decode(mode_eff);

  vsub_axis_gate #(.LEN(IMG_W)) u_gate_x (
    .pos_i      (col),
    .zoom_i     (geom.zoom),
    .dec_log2_i (geom.dec_log2),
    .keep_o     (keep_x)
  );

  vsub_axis_gate #(.LEN(IMG_H)) u_gate_y (
    .pos_i      (row),
    .zoom_i     (geom.zoom),
    .dec_log2_i (geom.dec_log2),
    .keep_o     (keep_y)
  );

  assign keep = frame_valid_i && line_valid_i && keep_x && keep_y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q        <= 3'(SZ_FULL);
      frame_valid_o <= 1'b0;
      line_valid_o  <= 1'b0;
      pix_o         <= '0;
      frame_start_o <= 1'b0;
      line_start_o  <= 1'b0;
      line_seen_q   <= 1'b0;
      frame_seen_q  <= 1'b0;
    end else begin
      if (frame_rise) mode_q <= size_i;
      frame_valid_o <= frame_valid_i;
      line_valid_o  <= keep;
      if (keep) pix_o <= pix_i;
      frame_start_o <= keep && !frame_seen_q;
      line_start_o  <= keep && !line_seen_q;
      line_seen_q   <= line_valid_i && (line_seen_q || keep);
      frame_seen_q  <= frame_valid_i && (frame_seen_q || keep);
    end
  end

  assert_lv_in_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> frame_valid_o);

  assert_ls_on_lv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> line_valid_o);

  assert_fs_is_ls_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_start_o);

  assert_mode_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && frame_valid_o) |=> $stable(mode_q));

endmodule

// File: tb/tb_vsub_select.sv
module tb_vsub_select;

  localparam int DW = 8;
  localparam int W  = 32;
  localparam int H  = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    size_i = 3'd0;
  logic          frame_valid_i = 1'b0, line_valid_i = 1'b0;
  logic [DW-1:0] pix_i = '0;
  logic          frame_valid_o, line_valid_o, frame_start_o, line_start_o;
  logic [DW-1:0] pix_o;

  vsub_select #(.DATA_W(DW), .IMG_W(W), .IMG_H(H)) dut (
    .clk_i, .rst_ni, .size_i, .frame_valid_i, .line_valid_i, .pix_i,
    .frame_valid_o, .line_valid_o, .pix_o, .frame_start_o, .line_start_o
  );

  always #2 clk_i = ~clk_i;

  int    vectors = 0, fails = 0, frame_no = 0;
  bit    done = 0;
  string tag = "R1";

  logic          exp_fv = 0, exp_lv = 0, exp_fs = 0, exp_ls = 0;
  logic [DW-1:0] exp_pix = '0;
  logic          prev_f = 0, lseen = 0, fseen = 0;
  logic [2:0]    fmode = 0;

  function automatic logic [DW-1:0] pat(int r, int c);
    return DW'(r * 13 + c * 7 + frame_no * 29);
  endfunction

  // keep rule per axis from the requirements
  function automatic bit axis_keep(int pos, int len, int md);
    int lo, hi, step;
    bit zoom;
    zoom = (md == 2 || md == 4);
    step = (md == 1 || md == 4) ? 2 : (md == 3) ? 4 : 1;
    lo = zoom ? len / 4 + 1 : 1;
    hi = zoom ? (3 * len) / 4 : len;
    return pos >= lo && pos <= hi && ((pos - lo) % step) == 0;
  endfunction

  task automatic step(input logic f, input logic l, input int r, input int c);
    bit bad;
    bit k;
    @(negedge clk_i);
    bad = 0;
    if (frame_valid_o !== exp_fv) begin
      $display("FAIL R8 frame_valid_o act=%0b exp=%0b", frame_valid_o, exp_fv); bad = 1;
    end
    if (line_valid_o !== exp_lv) begin
      $display("FAIL %s R9 line_valid_o act=%0b exp=%0b", tag, line_valid_o, exp_lv); bad = 1;
    end
    if (exp_lv && pix_o !== exp_pix) begin
      $display("FAIL R8 pix_o act=%0h exp=%0h", pix_o, exp_pix); bad = 1;
    end
    if (frame_start_o !== exp_fs) begin
      $display("FAIL R10 frame_start_o act=%0b exp=%0b", frame_start_o, exp_fs); bad = 1;
    end
    if (line_start_o !== exp_ls) begin
      $display("FAIL R10 line_start_o act=%0b exp=%0b", line_start_o, exp_ls); bad = 1;
    end
    vectors++;
    if (bad) fails++;
    frame_valid_i = f;
    line_valid_i  = l;
    pix_i         = l ? pat(r, c) : '0;
    if (f && !prev_f) fmode = size_i;
    k = f && l && axis_keep(c, W, int'(fmode)) && axis_keep(r, H, int'(fmode));
    exp_fv = f;
    exp_lv = k;
    if (k) exp_pix = pat(r, c);
    exp_fs = k && !fseen;
    exp_ls = k && !lseen;
    lseen  = l && (lseen || k);
    fseen  = f && (fseen || k);
    prev_f = f;
  endtask

  // change_row > 0: switch size_i to change_to before that row (R7)
  task automatic frame(input logic [2:0] md, input string t,
                       input int change_row, input logic [2:0] change_to);
    size_i = md;
    tag = t;
    frame_no++;
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    for (int r = 1; r <= H; r++) begin
      if (r == change_row) size_i = change_to;
      for (int c = 1; c <= W; c++) step(1, 1, r, c);
      for (int b = 0; b < 3; b++) step(1, 0, 0, 0);
    end
    step(1, 0, 0, 0);
    for (int b = 0; b < 4; b++) step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    vectors++;
    if (frame_valid_o !== 0 || line_valid_o !== 0 || frame_start_o !== 0 || line_start_o !== 0) begin
      fails++;
      $display("FAIL R1 reset outputs act=%b%b%b%b exp=0000",
               frame_valid_o, line_valid_o, frame_start_o, line_start_o);
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);  // R1 after release
    frame(3'd0, "R2 R11", 0, 3'd0);
    frame(3'd1, "R3 R11", 0, 3'd0);
    frame(3'd2, "R4", 0, 3'd0);
    frame(3'd3, "R5", 0, 3'd0);
    frame(3'd4, "R6", 0, 3'd0);
    frame(3'd6, "R2", 0, 3'd0);
    frame(3'd1, "R7", 6, 3'd2);
    frame(3'd4, "R7", 10, 3'd0);
    frame(3'd7, "R2", 0, 3'd0);
    step(0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule